// File: doc/BRIEF.md
# Warp Divergence Mask Stack

This block keeps the active-lane mask of a single 32-lane warp as the warp runs through conditional branches. On each branch, every lane supplies one predicate bit. Only the bits of lanes that are currently active count. If those lanes all agree, or if none of them takes the branch, the warp continues on a single path. In that case the mask does not change and the command costs one cycle.

If the active lanes disagree, the block serialises the two paths. The taken subset runs first. The not-taken subset runs next. The full pre-branch mask comes back at the join PC. Nothing is predicted or flushed; the only cost of divergence is that fewer lanes are useful on each issued instruction.

Pending work is held on an internal stack. Each entry holds a resume PC, a lane mask and the PC at which the entry is released. A divergent branch pushes two entries: a rejoin entry, carrying the full mask, and a deferred entry, carrying the not-taken subset. Pushing two entries takes two cycles, so `ready` is low for one cycle. The fetch side reports each PC that the warp reaches with a sync command. If that PC equals the release PC of the top entry, the entry is popped, and its mask and resume PC take effect.

Top module: `warp_mask_stack`

## Requirements
- R1: After reset, `active_mask` is 32'hFFFFFFFF, `ready` is 1, `pc_valid` is 0, `overflow_err` is 0 and the stack is empty.
- R2: A branch in which every active lane has its predicate bit set produces, one cycle later, `next_pc` equal to `br_target` with `pc_valid` 1. `active_mask` does not change and `ready` stays 1.
- R3: A branch in which no active lane has its predicate bit set produces, one cycle later, `next_pc` equal to `br_fallthru` with `pc_valid` 1. `active_mask` does not change and nothing is pushed.
- R4: Predicate bits of inactive lanes have no effect on the outcome of a branch.
- R5: A branch that splits the active lanes drives `ready` low for exactly one cycle. One cycle after that, `active_mask` equals the taken subset (predicate AND mask), `next_pc` equals `br_target` and `pc_valid` is 1.
- R6: A sync command whose `sync_pc` equals the release PC of the top stack entry pops that entry. One cycle later, `active_mask` and `next_pc` take the entry's mask and resume PC, and `pc_valid` is 1.
- R7: A sync command on an empty stack, or with a PC that does not match the top entry, changes nothing, and `pc_valid` stays 0.
- R8: After a split, the order is: the taken subset at `br_target`; then, on reaching the join PC, the not-taken subset at `br_fallthru`; then, on reaching the join PC again, the full pre-branch mask at the join PC.
- R9: Splits nest. Inner splits rejoin before the outer ones, and each level restores the mask that was active when that level's branch was issued.
- R10: A divergent branch issued when fewer than two stack entries are free sets `overflow_err`. The flag stays set until reset. Such a branch pushes nothing and leaves `active_mask` and `next_pc` unchanged.
- R11: With the default depth of 32, a chain of 31 nested single-lane splits is supported, ending in a pass with only lane 31 active. Unwinding the chain restores the full mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_branch | input | 1 | Branch command, accepted when `ready` is 1 |
| cmd_sync | input | 1 | Reached-PC command, accepted when `ready` is 1 and `cmd_branch` is 0 |
| lane_pred | input | 32 | Predicate bit per lane, bit i for lane i |
| br_target | input | PCW | PC of the taken path |
| br_fallthru | input | PCW | PC of the not-taken path |
| br_join | input | PCW | PC where the two paths rejoin |
| sync_pc | input | PCW | PC the warp has just reached |
| active_mask | output | 32 | Current active lanes, bit i for lane i |
| next_pc | output | PCW | PC at which the warp continues |
| pc_valid | output | 1 | One-cycle pulse when `next_pc` has been updated |
| ready | output | 1 | Low during the second cycle of a divergent branch |
| overflow_err | output | 1 | Sticky stack overflow flag |

## Verification
The in-RTL properties assume three things about the inputs:
- A command is issued only while `ready` is high.
- `cmd_branch` and `cmd_sync` are never raised together.
- The join PC of every branch is a PC that both paths later report through a sync command.

The stimulus drives each command for exactly one clock and waits out the stall before issuing the next. It reports each join PC once per path, in the order a real warp would reach it. Lane splits are always chosen so that each path keeps at least one active lane.

// File: rtl/warp_mask_stack.sv
module warp_mask_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 32,
  parameter int PCW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_branch,
  input  logic             cmd_sync,
  input  logic [LANES-1:0] lane_pred,
  input  logic [PCW-1:0]   br_target,
  input  logic [PCW-1:0]   br_fallthru,
  input  logic [PCW-1:0]   br_join,
  input  logic [PCW-1:0]   sync_pc,
  output logic [LANES-1:0] active_mask,
  output logic [PCW-1:0]   next_pc,
  output logic             pc_valid,
  output logic             ready,
  output logic             overflow_err
);

  localparam int SPW = $clog2(DEPTH + 1);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SPW-1:0] ROOM_LIM = SPW'(DEPTH - 2);

  logic [PCW-1:0]   st_pc   [DEPTH];
  logic [PCW-1:0]   st_wait [DEPTH];
  logic [LANES-1:0] st_mask [DEPTH];

  logic [SPW-1:0]   sp;
  logic             busy;
  logic [LANES-1:0] pend_tk, pend_nt;
  logic [PCW-1:0]   pend_tgt, pend_fall, pend_join;

  wire [LANES-1:0] tk   = lane_pred & active_mask;
  wire [LANES-1:0] nt   = ~lane_pred & active_mask;
  wire             none = (tk == '0);
  wire             all  = (tk == active_mask);
  wire             room = (sp <= ROOM_LIM);
  wire [SPW-1:0]   top  = sp - 1'b1;
  wire [AW-1:0]    wr_ix = sp[AW-1:0];
  wire [AW-1:0]    rd_ix = top[AW-1:0];
  wire             hit  = (sp != '0) && (sync_pc == st_wait[rd_ix]);
  wire             br_go = cmd_branch && !busy;
  wire             sy_go = cmd_sync && !cmd_branch && !busy && hit;

  assign ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_mask  <= '1;
      next_pc      <= '0;
      pc_valid     <= 1'b0;
      busy         <= 1'b0;
      sp           <= '0;
      overflow_err <= 1'b0;
      pend_tk      <= '0;
      pend_nt      <= '0;
      pend_tgt     <= '0;
      pend_fall    <= '0;
      pend_join    <= '0;
    end else begin
      pc_valid <= 1'b0;
      if (busy) begin
        st_pc[wr_ix]   <= pend_fall;
        st_mask[wr_ix] <= pend_nt;
        st_wait[wr_ix] <= pend_join;
        sp             <= sp + 1'b1;
        active_mask    <= pend_tk;
        next_pc        <= pend_tgt;
        pc_valid       <= 1'b1;
        busy           <= 1'b0;
      end else if (br_go) begin
        if (all || none) begin
          next_pc  <= none ? br_fallthru : br_target;
          pc_valid <= 1'b1;
        end else if (!room) begin
          overflow_err <= 1'b1;
        end else begin
          st_pc[wr_ix]   <= br_join;
          st_mask[wr_ix] <= active_mask;
          st_wait[wr_ix] <= br_join;
          sp             <= sp + 1'b1;
          busy           <= 1'b1;
          pend_tk        <= tk;
          pend_nt        <= nt;
          pend_tgt       <= br_target;
          pend_fall      <= br_fallthru;
          pend_join      <= br_join;
        end
      end else if (sy_go) begin
        active_mask <= st_mask[rd_ix];
        next_pc     <= st_pc[rd_ix];
        pc_valid    <= 1'b1;
        sp          <= top;
      end
    end
  end

  // R5
  mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_mask != '0);

  // R5
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);

  // R5
  split_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ((active_mask & ~$past(active_mask)) == '0) && pc_valid);

  // R2
  uniform_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_branch && ready && (((lane_pred & active_mask) == active_mask) ||
     ((lane_pred & active_mask) == '0))) |=> $stable(active_mask) && pc_valid && ready);

  // R7
  empty_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sync && !cmd_branch && ready && sp == '0) |=> !pc_valid && $stable(active_mask));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));

endmodule

// File: tb/sim_warp_mask_stack.sv
module sim_warp_mask_stack;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_branch = 1'b0, cmd_sync = 1'b0;
  logic [31:0] lane_pred = '0, br_target = '0, br_fallthru = '0, br_join = '0, sync_pc = '0;
  logic [31:0] active_mask, next_pc;
  logic        pc_valid, ready, overflow_err;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  warp_mask_stack u0 (
    .clk(clk), .rst_n(rst_n), .cmd_branch(cmd_branch), .cmd_sync(cmd_sync),
    .lane_pred(lane_pred), .br_target(br_target), .br_fallthru(br_fallthru),
    .br_join(br_join), .sync_pc(sync_pc), .active_mask(active_mask),
    .next_pc(next_pc), .pc_valid(pc_valid), .ready(ready), .overflow_err(overflow_err)
  );

  typedef struct packed {
    logic        is_sync;
    logic [31:0] pred;
    logic [15:0] a;      // target, or sync pc
    logic [15:0] b;      // fallthrough
    logic [15:0] c;      // join
    logic [31:0] emask;
    logic [15:0] epc;
    logic        ev;
    logic        es;     // expected stall
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'hFFFFFFFF, 16'h10, 16'h04, 16'h20, 32'hFFFFFFFF, 16'h10, 1'b1, 1'b0, 4'd2},  // R2
    '{1'b0, 32'h00000000, 16'h12, 16'h04, 16'h20, 32'hFFFFFFFF, 16'h04, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b1, 32'h0,        16'h99, 16'h00, 16'h00, 32'hFFFFFFFF, 16'h04, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 32'h0000FFFF, 16'h30, 16'h08, 16'h40, 32'h0000FFFF, 16'h30, 1'b1, 1'b1, 4'd5},  // R5
    '{1'b1, 32'h0,        16'h35, 16'h00, 16'h00, 32'h0000FFFF, 16'h30, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 32'h000000FF, 16'h50, 16'h34, 16'h38, 32'h000000FF, 16'h50, 1'b1, 1'b1, 4'd9},  // R9
    '{1'b0, 32'hFFFFFF00, 16'h60, 16'h52, 16'h58, 32'h000000FF, 16'h52, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b0, 32'hFF0000FF, 16'h54, 16'h53, 16'h00, 32'h000000FF, 16'h54, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 32'h0,        16'h38, 16'h00, 16'h00, 32'h0000FF00, 16'h34, 1'b1, 1'b0, 4'd8},  // R8
    '{1'b1, 32'h0,        16'h38, 16'h00, 16'h00, 32'h0000FFFF, 16'h38, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b1, 32'h0,        16'h40, 16'h00, 16'h00, 32'hFFFF0000, 16'h08, 1'b1, 1'b0, 4'd6},  // R6
    '{1'b1, 32'h0,        16'h40, 16'h00, 16'h00, 32'hFFFFFFFF, 16'h40, 1'b1, 1'b0, 4'd8},  // R8
    '{1'b1, 32'h0,        16'h40, 16'h00, 16'h00, 32'hFFFFFFFF, 16'h40, 1'b0, 1'b0, 4'd7}   // R7
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic do_branch(input logic [31:0] p, t, f, j, output logic stalled);
    @(negedge clk);
    lane_pred = p; br_target = t; br_fallthru = f; br_join = j; cmd_branch = 1'b1;
    @(negedge clk);
    cmd_branch = 1'b0;
    stalled = !ready;
    if (stalled) @(negedge clk);
  endtask

  task automatic do_sync(input logic [31:0] pc);
    @(negedge clk);
    sync_pc = pc; cmd_sync = 1'b1;
    @(negedge clk);
    cmd_sync = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset mask", active_mask, 32'hFFFFFFFF);
    chk("R1 reset ready", {31'b0, ready}, 32'd1);
    chk("R1 reset pc_valid", {31'b0, pc_valid}, 32'd0);
    chk("R1 reset overflow", {31'b0, overflow_err}, 32'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    logic st;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_sync) begin
        do_sync({16'h0, VEC[i].a});
        st = 1'b0;
      end else begin
        do_branch(VEC[i].pred, {16'h0, VEC[i].a}, {16'h0, VEC[i].b}, {16'h0, VEC[i].c}, st);
      end
      chk($sformatf("R%0d row %0d mask", VEC[i].req, i), active_mask, VEC[i].emask);
      chk($sformatf("R%0d row %0d next_pc", VEC[i].req, i), next_pc, {16'h0, VEC[i].epc});
      chk($sformatf("R%0d row %0d pc_valid", VEC[i].req, i), {31'b0, pc_valid}, {31'b0, VEC[i].ev});
      chk($sformatf("R%0d row %0d stall", VEC[i].req, i), {31'b0, st}, {31'b0, VEC[i].es});
    end

    // R10 and R9: sixteen nested splits fill the stack, the seventeenth overflows
    for (int k = 0; k < 16; k++) begin
      do_branch(32'hFFFFFFFF << (k + 1), 100 + k, 200 + k, 300 + k, st);
      chk($sformatf("R9 nest %0d mask", k), active_mask, 32'hFFFFFFFF << (k + 1));
      chk($sformatf("R9 nest %0d pc", k), next_pc, 100 + k);
    end
    do_branch(32'hFFFE0000, 500, 501, 502, st);
    chk("R10 overflow set", {31'b0, overflow_err}, 32'd1);
    chk("R10 overflow no stall", {31'b0, st}, 32'd0);
    chk("R10 overflow mask kept", active_mask, 32'hFFFF0000);
    chk("R10 overflow pc kept", next_pc, 115);
    chk("R10 overflow no pc_valid", {31'b0, pc_valid}, 32'd0);
    for (int k = 15; k >= 0; k--) begin
      do_sync(300 + k);
      chk($sformatf("R8 unwind %0d deferred mask", k), active_mask, 32'h1 << k);
      chk($sformatf("R8 unwind %0d deferred pc", k), next_pc, 200 + k);
      do_sync(300 + k);
      chk($sformatf("R9 unwind %0d rejoin mask", k), active_mask, 32'hFFFFFFFF << k);
      chk($sformatf("R9 unwind %0d rejoin pc", k), next_pc, 300 + k);
    end
    chk("R10 overflow still set", {31'b0, overflow_err}, 32'd1);

    do_reset();

    // R11: 32-way chain of single-lane splits
    for (int k = 0; k < 31; k++) begin
      do_branch(32'h1 << k, 100 + k, 200 + k, 300 + k, st);
      chk($sformatf("R11 lane %0d taken mask", k), active_mask, 32'h1 << k);
      chk($sformatf("R11 lane %0d stall", k), {31'b0, st}, 32'd1);
      do_sync(300 + k);
      chk($sformatf("R11 lane %0d rest mask", k), active_mask, 32'hFFFFFFFF << (k + 1));
      chk($sformatf("R11 lane %0d rest pc", k), next_pc, 200 + k);
    end
    chk("R11 last single lane", active_mask, 32'h80000000);
    chk("R11 no overflow", {31'b0, overflow_err}, 32'd0);
    for (int k = 30; k >= 0; k--) begin
      do_sync(300 + k);
      chk($sformatf("R11 rejoin %0d mask", k), active_mask, 32'hFFFFFFFF << k);
      chk($sformatf("R11 rejoin %0d pc", k), next_pc, 300 + k);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule